// File: doc/BRIEF.md
# Adaptive Gain Adjustment Loop

This block keeps a 32-bit digital gain word. A stream of 8-bit sample magnitudes steers the word. Each accepted magnitude moves a signed adjustment by one programmable step, which is added to or subtracted from the adjustment. The gain word is a static initial gain plus this adjustment. Four step sizes can be programmed:

- a small one that raises the gain when the magnitude is under a threshold;
- one that lowers the gain when the magnitude is at or over the threshold;
- a fast-attack raise used when the signal has stayed near zero for some time;
- a fast-decay lower used when the signal has stayed saturated for some time.

Each step value is shifted left by a programmable amount, so it lands at a chosen bit position below the top half of the word.

Two 4-bit up/down counters track persistence. One counter follows masked near-zero samples. The other follows magnitudes above a programmable ceiling. Asymmetric upper and lower limits, expressed in the top 16 bits, stop the adjustment from running further in either direction. Complex data is fed as I then Q, two ordinary samples one after another, so each produces its own adjustment in that order.

Further controls:

- A freeze input halts all adaptation.
- A sync input clears the loop and loads the initial gain from two 16-bit halves.
- Holding sync and freeze together gives a fixed static gain.

The sample input is a valid/ready stream:

- A sample is taken on a clock edge where both valid and ready are high.
- Ready is low only while sync is high, so samples offered during sync are not consumed.
- While ready is low, the source must hold its sample.

Top module: `agc_gain_loop`

## Requirements
- R1: After reset the gain output is 0, the adjustment is 0 and both persistence counters are 0.
- R2: While sync is high, s_ready is low. On the edge after a sync cycle, the gain equals {cfg_gain_hi, cfg_gain_lo}, the adjustment is 0 and both counters are 0.
- R3: An accepted sample with magnitude below cfg_thresh, when no persistence mode is active, adds cfg_step_blw shifted left by cfg_step_shift to the adjustment.
- R4: An accepted sample with magnitude at or above cfg_thresh, when no persistence mode is active, subtracts cfg_step_abv shifted left by cfg_step_shift.
- R5: The near-zero counter counts up when (magnitude AND cfg_zero_mask) is zero and down otherwise, saturating at 0 and 15. If its value after this sample exceeds cfg_zero_lim, the adjustment is raised by cfg_step_zro shifted.
- R6: The saturation counter counts up when the magnitude exceeds cfg_max_mag and down otherwise, saturating at 0 and 15. If its value after this sample exceeds cfg_sat_lim, the adjustment is lowered by cfg_step_sat shifted.
- R7: Priority is saturation first, then near-zero, then the threshold comparison.
- R8: A raise is applied only while the adjustment is at or below {cfg_lim_up, 16'h0}; otherwise the adjustment is unchanged.
- R9: A lowering is applied only while the adjustment is at or above -{cfg_lim_dn, 16'h0}; otherwise the adjustment is unchanged.
- R10: While freeze is high, accepted samples change neither the gain nor either counter.
- R11: A cycle with no accepted sample leaves the gain unchanged. Back-to-back accepted samples (I then Q) each apply their own adjustment in arrival order.
- R12: With sync and freeze both held high, the gain stays at {cfg_gain_hi, cfg_gain_lo} whatever samples arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high together with valid |
| s_mag | input | 8 | Sample magnitude |
| freeze | input | 1 | Halt adaptation |
| sync | input | 1 | Clear loop and load initial gain |
| cfg_gain_hi | input | 16 | Initial gain, upper half |
| cfg_gain_lo | input | 16 | Initial gain, lower half |
| cfg_thresh | input | 8 | Magnitude threshold |
| cfg_zero_mask | input | 8 | Mask applied before the near-zero test |
| cfg_zero_lim | input | 4 | Near-zero counter limit |
| cfg_max_mag | input | 8 | Saturation magnitude ceiling |
| cfg_sat_lim | input | 4 | Saturation counter limit |
| cfg_step_blw | input | 8 | Step below threshold |
| cfg_step_abv | input | 8 | Step at or above threshold |
| cfg_step_zro | input | 8 | Near-zero step |
| cfg_step_sat | input | 8 | Saturation step |
| cfg_step_shift | input | 4 | Left shift applied to every step |
| cfg_lim_up | input | 16 | Upper adjustment limit, top half aligned |
| cfg_lim_dn | input | 16 | Lower adjustment limit magnitude, top half aligned |
| gain | output | 32 | Gain word |

## Verification
The hardest case to reach from the ports is one where the saturation and near-zero modes are active at once. A single magnitude cannot normally be both near zero and above the ceiling. The stimulus therefore clears the zero mask, so that every sample counts as near zero, and then feeds full-scale samples until both counters pass their limits; the step taken must then be the saturation one. The freeze test follows the same approach. It feeds near-zero samples while frozen and then releases freeze. If the counter had moved during the freeze, the next sample would take the fast step instead of the normal raise, and the gain would show it.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    SEL_BLW = 2'd0,
    SEL_ABV = 2'd1,
    SEL_ZRO = 2'd2,
    SEL_SAT = 2'd3
  } step_sel_e;

  // direction of the adjustment for each selection
  function automatic logic sel_raises(input step_sel_e s);
    return (s == SEL_BLW) || (s == SEL_ZRO);
  endfunction
endpackage

// File: rtl/agc_persist_cnt.sv
module agc_persist_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             up,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nx
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  always_comb begin
    cnt_nx = cnt_q;
    if (up) begin
      if (cnt_q != CMAX) cnt_nx = cnt_q + 1'b1;
    end else begin
      if (cnt_q != '0) cnt_nx = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (en)  cnt_q <= cnt_nx;
  end

  // R5
  cnt_top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && up && cnt_q == CMAX) |=> cnt_q == CMAX);

  // R6
  cnt_floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && en && !up && cnt_q == '0) |=> cnt_q == '0);

  // R10
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/agc_step_sel.sv
module agc_step_sel
  import agc_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int STEP_W = 8
) (
  input  logic [CNT_W-1:0]  zero_cnt,
  input  logic [CNT_W-1:0]  sat_cnt,
  input  logic [CNT_W-1:0]  zero_lim,
  input  logic [CNT_W-1:0]  sat_lim,
  input  logic              below,
  input  logic [STEP_W-1:0] d_blw,
  input  logic [STEP_W-1:0] d_abv,
  input  logic [STEP_W-1:0] d_zro,
  input  logic [STEP_W-1:0] d_sat,
  output logic [STEP_W-1:0] step_d,
  output logic              raise
);
  step_sel_e sel;

  always_comb begin
    if (sat_cnt > sat_lim)        sel = SEL_SAT;
    else if (zero_cnt > zero_lim) sel = SEL_ZRO;
    else if (below)               sel = SEL_BLW;
    else                          sel = SEL_ABV;
  end

  always_comb begin
    unique case (sel)
      SEL_BLW: step_d = d_blw;
      SEL_ABV: step_d = d_abv;
      SEL_ZRO: step_d = d_zro;
      default: step_d = d_sat;
    endcase
    raise = sel_raises(sel);
  end
endmodule

// File: rtl/agc_adj_accum.sv
module agc_adj_accum #(
  parameter int HALF_W  = 16,
  parameter int STEP_W  = 8,
  parameter int SHIFT_W = 4,
  localparam int GAIN_W = 2 * HALF_W,
  localparam int ADJ_W  = GAIN_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync,
  input  logic               take,
  input  logic               freeze,
  input  logic               raise,
  input  logic [STEP_W-1:0]  step_d,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [HALF_W-1:0]  lim_up,
  input  logic [HALF_W-1:0]  lim_dn,
  input  logic [HALF_W-1:0]  g_hi,
  input  logic [HALF_W-1:0]  g_lo,
  output logic [GAIN_W-1:0]  gain
);
  logic signed [ADJ_W-1:0] adj_q, adj_nx, step_ext, up_full, dn_full;
  logic [GAIN_W-1:0]       g0_q;
  logic                    apply;

  always_comb begin
    step_ext = $signed({{(ADJ_W-STEP_W){1'b0}}, step_d} << shift);
    up_full  = $signed({2'b00, lim_up, {HALF_W{1'b0}}});
    dn_full  = -$signed({2'b00, lim_dn, {HALF_W{1'b0}}});
    apply    = take && !freeze;
    adj_nx   = adj_q;
    if (apply) begin
      if (raise) begin
        if (adj_q <= up_full) adj_nx = adj_q + step_ext;
      end else begin
        if (adj_q >= dn_full) adj_nx = adj_q - step_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q <= '0;
      g0_q  <= '0;
    end else if (sync) begin
      adj_q <= '0;
      g0_q  <= {g_hi, g_lo};
    end else begin
      adj_q <= adj_nx;
    end
  end

  assign gain = g0_q + adj_q[GAIN_W-1:0];

  // R8
  upper_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && adj_q > $signed({2'b00, lim_up, {HALF_W{1'b0}}})) |=> adj_q <= $past(adj_q));

  // R9
  lower_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && adj_q < -$signed({2'b00, lim_dn, {HALF_W{1'b0}}})) |=> adj_q >= $past(adj_q));

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && freeze) |=> adj_q == $past(adj_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !take) |=> gain == $past(gain));
endmodule

// File: rtl/agc_gain_loop.sv
module agc_gain_loop #(
  parameter int MAG_W   = 8,
  parameter int CNT_W   = 4,
  parameter int STEP_W  = 8,
  parameter int HALF_W  = 16,
  localparam int GAIN_W = 2 * HALF_W,
  localparam int SHIFT_W = $clog2(HALF_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [MAG_W-1:0]   s_mag,
  input  logic               freeze,
  input  logic               sync,
  input  logic [HALF_W-1:0]  cfg_gain_hi,
  input  logic [HALF_W-1:0]  cfg_gain_lo,
  input  logic [MAG_W-1:0]   cfg_thresh,
  input  logic [MAG_W-1:0]   cfg_zero_mask,
  input  logic [CNT_W-1:0]   cfg_zero_lim,
  input  logic [MAG_W-1:0]   cfg_max_mag,
  input  logic [CNT_W-1:0]   cfg_sat_lim,
  input  logic [STEP_W-1:0]  cfg_step_blw,
  input  logic [STEP_W-1:0]  cfg_step_abv,
  input  logic [STEP_W-1:0]  cfg_step_zro,
  input  logic [STEP_W-1:0]  cfg_step_sat,
  input  logic [SHIFT_W-1:0] cfg_step_shift,
  input  logic [HALF_W-1:0]  cfg_lim_up,
  input  logic [HALF_W-1:0]  cfg_lim_dn,
  output logic [GAIN_W-1:0]  gain
);
  logic take, cnt_en, is_zero, is_over, below, raise;
  logic [CNT_W-1:0]  zc_q, zc_nx, sc_q, sc_nx;
  logic [STEP_W-1:0] step_d;

  assign s_ready = !sync;
  assign take    = s_valid && s_ready;
  assign cnt_en  = take && !freeze;
  assign is_zero = (s_mag & cfg_zero_mask) == '0;
  assign is_over = s_mag > cfg_max_mag;
  assign below   = s_mag < cfg_thresh;

  agc_persist_cnt #(.CNT_W(CNT_W)) u_zero_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sync), .en(cnt_en), .up(is_zero),
    .cnt_q(zc_q), .cnt_nx(zc_nx)
  );

  agc_persist_cnt #(.CNT_W(CNT_W)) u_sat_cnt (
    .clk(clk), .rst_n(rst_n), .clr(sync), .en(cnt_en), .up(is_over),
    .cnt_q(sc_q), .cnt_nx(sc_nx)
  );

  agc_step_sel #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_sel (
    .zero_cnt(zc_nx), .sat_cnt(sc_nx),
    .zero_lim(cfg_zero_lim), .sat_lim(cfg_sat_lim), .below(below),
    .d_blw(cfg_step_blw), .d_abv(cfg_step_abv),
    .d_zro(cfg_step_zro), .d_sat(cfg_step_sat),
    .step_d(step_d), .raise(raise)
  );

  agc_adj_accum #(.HALF_W(HALF_W), .STEP_W(STEP_W), .SHIFT_W(SHIFT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .sync(sync), .take(take), .freeze(freeze),
    .raise(raise), .step_d(step_d), .shift(cfg_step_shift),
    .lim_up(cfg_lim_up), .lim_dn(cfg_lim_dn),
    .g_hi(cfg_gain_hi), .g_lo(cfg_gain_lo), .gain(gain)
  );

  // R2
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> gain == $past({cfg_gain_hi, cfg_gain_lo}));

  // R2
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (zc_q == '0 && sc_q == '0));

  // R12
  static_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && freeze && $past(sync) && $past(freeze) && $stable({cfg_gain_hi, cfg_gain_lo}))
      |=> $stable(gain));
endmodule

// File: tb/tb_agc_gain_loop.sv
module tb_agc_gain_loop;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, freeze = 0, sync = 0;
  logic [7:0]  s_mag = 0;
  logic [15:0] cfg_gain_hi = 0, cfg_gain_lo = 0, cfg_lim_up = 16'h0010, cfg_lim_dn = 16'h0010;
  logic [7:0]  cfg_thresh = 8'h40, cfg_zero_mask = 8'hF0, cfg_max_mag = 8'hF0;
  logic [3:0]  cfg_zero_lim = 4'd3, cfg_sat_lim = 4'd3, cfg_step_shift = 4'd4;
  logic [7:0]  cfg_step_blw = 8'd2, cfg_step_abv = 8'd1, cfg_step_zro = 8'd8, cfg_step_sat = 8'd16;
  logic [31:0] gain;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  longint m_adj = 0;
  logic [31:0] m_g0 = 0;
  int m_zc = 0, m_sc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_gain_loop dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_mag(s_mag),
    .freeze(freeze), .sync(sync), .cfg_gain_hi(cfg_gain_hi), .cfg_gain_lo(cfg_gain_lo),
    .cfg_thresh(cfg_thresh), .cfg_zero_mask(cfg_zero_mask), .cfg_zero_lim(cfg_zero_lim),
    .cfg_max_mag(cfg_max_mag), .cfg_sat_lim(cfg_sat_lim),
    .cfg_step_blw(cfg_step_blw), .cfg_step_abv(cfg_step_abv),
    .cfg_step_zro(cfg_step_zro), .cfg_step_sat(cfg_step_sat),
    .cfg_step_shift(cfg_step_shift), .cfg_lim_up(cfg_lim_up), .cfg_lim_dn(cfg_lim_dn),
    .gain(gain)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: drives one cycle at a negedge and pushes the model's expected gain
  task automatic cyc(input logic v, input logic [7:0] m, input logic fz, input logic sy,
                     input string tag);
    longint step, upf, dnf;
    bit rs;
    s_valid = v; s_mag = m; freeze = fz; sync = sy;
    if (sy) begin
      m_adj = 0; m_zc = 0; m_sc = 0; m_g0 = {cfg_gain_hi, cfg_gain_lo};
    end else if (v && !fz) begin
      m_zc = ((m & cfg_zero_mask) == 0) ? ((m_zc < 15) ? m_zc + 1 : 15) : ((m_zc > 0) ? m_zc - 1 : 0);
      m_sc = (m > cfg_max_mag) ? ((m_sc < 15) ? m_sc + 1 : 15) : ((m_sc > 0) ? m_sc - 1 : 0);
      if (m_sc > int'(cfg_sat_lim))       begin step = longint'(cfg_step_sat); rs = 0; end
      else if (m_zc > int'(cfg_zero_lim)) begin step = longint'(cfg_step_zro); rs = 1; end
      else if (m < cfg_thresh)            begin step = longint'(cfg_step_blw); rs = 1; end
      else                                begin step = longint'(cfg_step_abv); rs = 0; end
      step = step << cfg_step_shift;
      upf = longint'(cfg_lim_up) << 16;
      dnf = -(longint'(cfg_lim_dn) << 16);
      if (rs && m_adj <= upf) m_adj = m_adj + step;
      else if (!rs && m_adj >= dnf) m_adj = m_adj - step;
    end
    exp_q.push_back(m_g0 + m_adj[31:0]);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard after each active edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), gain, exp_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset gain", gain, 32'h0);
    // R2 sync loads the initial gain and drops ready
    cfg_gain_hi = 16'h1234; cfg_gain_lo = 16'h0000;
    sync = 1; #1;
    check("R2 ready low in sync", {31'h0, s_ready}, 32'h0);
    cyc(1, 8'h30, 0, 1, "R2 sync load");
    // R3 below threshold, R4 at/above threshold, R11 idle and back-to-back I/Q
    cyc(1, 8'h30, 0, 0, "R3 below step");
    cyc(1, 8'h40, 0, 0, "R4 at-threshold step");
    cyc(1, 8'h80, 0, 0, "R4 above step");
    cyc(0, 8'h05, 0, 0, "R11 idle no change");
    cyc(0, 8'hFF, 0, 0, "R11 idle no change");
    cyc(1, 8'h20, 0, 0, "R11 I sample");
    cyc(1, 8'hA0, 0, 0, "R11 Q sample");
    // R5 persistent near-zero
    for (int i = 0; i < 20; i++) cyc(1, 8'h05, 0, 0, "R5 near-zero run");
    cyc(1, 8'h30, 0, 0, "R5 counter down from top");
    // R6 persistent saturation
    for (int i = 0; i < 20; i++) cyc(1, 8'hFF, 0, 0, "R6 saturation run");
    cyc(1, 8'h80, 0, 0, "R6 counter down from top");
    // R7 both modes active: mask 0 makes every sample near zero
    cyc(0, 8'h00, 0, 1, "R2 resync");
    cfg_zero_mask = 8'h00;
    for (int i = 0; i < 6; i++) cyc(1, 8'hFF, 0, 0, "R7 saturation wins");
    cfg_zero_mask = 8'hF0;
    // R8 upper limit
    cyc(0, 8'h00, 0, 1, "R2 resync");
    cfg_lim_up = 16'h0001; cfg_step_shift = 4'd15; cfg_step_blw = 8'd255;
    for (int i = 0; i < 4; i++) cyc(1, 8'h30, 0, 0, "R8 upper stop");
    // R9 lower limit
    cyc(0, 8'h00, 0, 1, "R2 resync");
    cfg_lim_dn = 16'h0002; cfg_step_abv = 8'd255;
    for (int i = 0; i < 4; i++) cyc(1, 8'h80, 0, 0, "R9 lower stop");
    for (int i = 0; i < 2; i++) cyc(1, 8'h30, 0, 0, "R8 raise from low side");
    cfg_step_shift = 4'd4; cfg_step_blw = 8'd2; cfg_step_abv = 8'd1;
    cfg_lim_up = 16'h0010; cfg_lim_dn = 16'h0010;
    // R10 freeze holds gain and counters
    cyc(0, 8'h00, 0, 1, "R2 resync");
    for (int i = 0; i < 6; i++) cyc(1, 8'h05, 1, 0, "R10 frozen");
    cyc(1, 8'h05, 0, 0, "R10 counters held");
    // R12 static gain
    cfg_gain_hi = 16'h0ABC; cfg_gain_lo = 16'h5555;
    for (int i = 0; i < 6; i++) cyc(1, (i % 2) ? 8'hFF : 8'h01, 1, 1, "R12 static gain");
    cyc(0, 8'h00, 0, 0, "R12 release");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule